// File: doc/BRIEF.md
# Dual-Channel Base-and-Limit Address Relocator

This block sits between the address-generation logic of a pipelined processor without paging and its memory system. It gives each program a private, position-independent window of physical memory. There are two independent channels. The fetch channel relocates instruction addresses through a program window. The data channel relocates load/store addresses through a separate data window. Each window is a pair: a base that is added to the logical address, and a limit that holds the window length. A logical address is legal only when it is strictly below the limit. An illegal request is held back from memory and flagged on the fault output of its own channel.

The data channel takes the register operand and the immediate offset as separate inputs. It sums them with the base in one carry-save stage followed by a single carry-propagate adder, so address generation and relocation share one adder delay. The limit check uses the logical address, which is the register plus immediate sum, before the base is added. All four window registers sit behind a configuration port that honours only supervisor-mode accesses. A user-mode attempt to access them changes nothing and raises a privilege error. Translation is combinational. A configuration write takes effect from the clock edge that follows it.

Top module: `reloc_bb_unit`

## Requirements
- R1: After a synchronous active-low reset, all four window registers read as zero. Both limits are zero, so every request on either channel faults.
- R2: The fetch channel drives a physical address equal to the fetch address plus the program base, modulo 2^32.
- R3: The data channel drives a physical address equal to data base + register operand + immediate, modulo 2^32. Its logical address is register operand + immediate, modulo 2^32.
- R4: A request whose logical address is below its channel's limit (unsigned) passes, and the channel's outgoing valid follows the request. An address equal to or above the limit raises that channel's fault and holds its outgoing valid low.
- R5: With no request on a channel, its outgoing valid and its fault are both low, whatever the address.
- R6: Fetch uses only the program pair, and data uses only the data pair. A fault on one channel does not affect the other.
- R7: A supervisor write to the register selected by cfg_sel updates it at the next clock edge. The encoding is 0 = program base, 1 = program limit, 2 = data base, 3 = data limit.
- R8: A user-mode write leaves all registers unchanged and asserts cfg_priv_err in the same cycle.
- R9: A supervisor read returns the selected register on cfg_rdata. A user-mode read returns zero and asserts cfg_priv_err.
- R10: When a configuration write and a request fall in the same cycle, the request uses the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_supervisor | input | 1 | High when the processor is in supervisor mode |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_sel | input | 2 | Register select (0 prog base, 1 prog limit, 2 data base, 3 data limit) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (zero unless a supervisor read) |
| cfg_priv_err | output | 1 | Configuration access attempted in user mode |
| if_req | input | 1 | Fetch request |
| if_addr | input | 32 | Logical fetch address |
| if_req_out | output | 1 | Fetch request forwarded to memory |
| if_paddr | output | 32 | Relocated fetch address |
| if_fault | output | 1 | Fetch limit violation |
| dm_req | input | 1 | Load/store request |
| dm_rs1 | input | 32 | Register operand |
| dm_imm | input | 32 | Immediate offset |
| dm_req_out | output | 1 | Data request forwarded to memory |
| dm_paddr | output | 32 | Relocated data address |
| dm_fault | output | 1 | Data limit violation |

## Verification
A configuration write and a translation can fall in the same cycle, and the order between them is what matters. The bench drives a supervisor write to a base or a limit together with a live request. It checks, before the edge, that the request still sees the old value. After the edge it checks that the same request sees the new value. Random traffic mixes writes, user-mode attempts and requests on both channels. Each result is judged against a bench model of the four registers.

// File: rtl/reloc_pkg.sv
// Package: shared encodings for the relocation unit.
// Assumes: the configuration select is two bits wide.
package reloc_pkg;
    localparam int unsigned CFG_SEL_W = 2;
    localparam int unsigned CFG_NREGS = 4;

    // Select encoding of the window registers
    typedef enum logic [CFG_SEL_W-1:0] {
        SEL_PROG_BASE  = 2'd0,
        SEL_PROG_LIMIT = 2'd1,
        SEL_DATA_BASE  = 2'd2,
        SEL_DATA_LIMIT = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/reloc_cfg_regs.sv
// Module: reloc_cfg_regs
// Holds the four window registers and the privileged access port for them.
// Assumes: the write takes effect at the clock edge; reads are combinational;
// any access in user mode is dropped and flagged.
module reloc_cfg_regs
    import reloc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 supervisor,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [CFG_SEL_W-1:0] sel,
    input  logic [W-1:0]         wdata,
    output logic [W-1:0]         rdata,
    output logic                 priv_err,
    output logic [W-1:0]         prog_base,
    output logic [W-1:0]         prog_limit,
    output logic [W-1:0]         data_base,
    output logic [W-1:0]         data_limit
);
    logic [W-1:0] regs_q [CFG_NREGS];
    logic         wr_ok;

    // Gate a write on supervisor mode
    always_comb wr_ok = wr_en & supervisor;

    // Flag any access tried from user mode
    always_comb priv_err = (wr_en | rd_en) & ~supervisor;

    // Return the selected register only on a supervisor read
    always_comb rdata = (rd_en & supervisor) ? regs_q[sel] : '0;

    for (genvar g = 0; g < CFG_NREGS; g++) begin : g_reg
        // Update one window register on a privileged write that selects it
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr_ok && (sel == CFG_SEL_W'(g)))
                regs_q[g] <= wdata;
        end

        assert_sup_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && supervisor && (sel == CFG_SEL_W'(g))) |=> (regs_q[g] == $past(wdata)));

        assert_user_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !supervisor) |=> $stable(regs_q[g]));
    end

    // Name the registers for the channels
    always_comb begin
        prog_base  = regs_q[SEL_PROG_BASE];
        prog_limit = regs_q[SEL_PROG_LIMIT];
        data_base  = regs_q[SEL_DATA_BASE];
        data_limit = regs_q[SEL_DATA_LIMIT];
    end
endmodule

// File: rtl/reloc_csa3.sv
// Module: reloc_csa3
// Adds three operands with one carry-save layer and one carry-propagate adder.
// Assumes: the result wraps modulo 2^W.
module reloc_csa3 #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum
);
    logic [W-1:0] s_vec;
    logic [W-1:0] c_vec;

    for (genvar i = 0; i < W; i++) begin : g_fa
        // Full adder per bit: partial sum and carry out
        always_comb begin
            s_vec[i] = a[i] ^ b[i] ^ c[i];
            c_vec[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
        end
    end

    // Single carry-propagate add of the shifted carry vector
    always_comb sum = s_vec + {c_vec[W-2:0], 1'b0};
endmodule

// File: rtl/reloc_channel.sv
// Module: reloc_channel
// One relocation channel: forms the logical address, checks it against the
// limit and relocates it by the base. HAS_OFFSET picks the three-operand
// carry-save path; otherwise the physical address is a two-operand add.
// Assumes: op_b is tied to zero when HAS_OFFSET is 0.
module reloc_channel #(
    parameter int unsigned W          = 32,
    parameter bit          HAS_OFFSET = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] base,
    input  logic [W-1:0] limit,
    output logic         req_out,
    output logic [W-1:0] paddr,
    output logic         fault
);
    logic [W-1:0] laddr;
    logic         in_range;

    // Logical address seen by the limit check
    always_comb laddr = op_a + op_b;

    // Unsigned strict-below comparison against the window length
    always_comb in_range = (laddr < limit);

    // Forward a legal request; flag an illegal one
    always_comb begin
        req_out = req & in_range;
        fault   = req & ~in_range;
    end

    if (HAS_OFFSET) begin : g_csa
        reloc_csa3 #(.W(W)) u_csa (
            .a  (op_a),
            .b  (op_b),
            .c  (base),
            .sum(paddr)
        );

        assert_csa_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
            req |-> (paddr == laddr + base));
    end else begin : g_add
        // Two-operand relocation
        always_comb paddr = laddr + base;
    end
endmodule

// File: rtl/reloc_bb_unit.sv
// Module: reloc_bb_unit
// Top of the dual-window relocation unit: a fetch channel on the program
// window, a data channel on the data window, and privileged configuration.
// Assumes: translation is combinational; window changes apply after the edge.
module reloc_bb_unit
    import reloc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_supervisor,
    input  logic                 cfg_wr_en,
    input  logic                 cfg_rd_en,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    output logic [ADDR_W-1:0]    cfg_rdata,
    output logic                 cfg_priv_err,
    input  logic                 if_req,
    input  logic [ADDR_W-1:0]    if_addr,
    output logic                 if_req_out,
    output logic [ADDR_W-1:0]    if_paddr,
    output logic                 if_fault,
    input  logic                 dm_req,
    input  logic [ADDR_W-1:0]    dm_rs1,
    input  logic [ADDR_W-1:0]    dm_imm,
    output logic                 dm_req_out,
    output logic [ADDR_W-1:0]    dm_paddr,
    output logic                 dm_fault
);
    logic [ADDR_W-1:0] prog_base, prog_limit, data_base, data_limit;

    reloc_cfg_regs #(.W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .supervisor(cfg_supervisor),
        .wr_en     (cfg_wr_en),
        .rd_en     (cfg_rd_en),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .priv_err  (cfg_priv_err),
        .prog_base (prog_base),
        .prog_limit(prog_limit),
        .data_base (data_base),
        .data_limit(data_limit)
    );

    reloc_channel #(.W(ADDR_W), .HAS_OFFSET(1'b0)) u_fetch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (if_req),
        .op_a   (if_addr),
        .op_b   ('0),
        .base   (prog_base),
        .limit  (prog_limit),
        .req_out(if_req_out),
        .paddr  (if_paddr),
        .fault  (if_fault)
    );

    reloc_channel #(.W(ADDR_W), .HAS_OFFSET(1'b1)) u_data (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (dm_req),
        .op_a   (dm_rs1),
        .op_b   (dm_imm),
        .base   (data_base),
        .limit  (data_limit),
        .req_out(dm_req_out),
        .paddr  (dm_paddr),
        .fault  (dm_fault)
    );

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (prog_base == '0 && prog_limit == '0 && data_base == '0 && data_limit == '0));

    assert_zero_limit_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_limit == '0) |-> !if_req_out);

    assert_fetch_over_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && (if_addr >= prog_limit)) |-> (if_fault && !if_req_out));

    assert_fetch_reloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        if_req_out |-> (if_paddr == if_addr + prog_base));
endmodule

// File: tb/test_reloc_bb_unit.sv
module test_reloc_bb_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_supervisor, cfg_wr_en, cfg_rd_en;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        cfg_priv_err;
    logic        if_req, if_req_out, if_fault;
    logic [31:0] if_addr, if_paddr;
    logic        dm_req, dm_req_out, dm_fault;
    logic [31:0] dm_rs1, dm_imm, dm_paddr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] m_reg [4];

    always #2 clk = ~clk;

    reloc_bb_unit i_reloc_bb_unit (
        .clk(clk), .rst_n(rst_n),
        .cfg_supervisor(cfg_supervisor), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_priv_err(cfg_priv_err),
        .if_req(if_req), .if_addr(if_addr), .if_req_out(if_req_out),
        .if_paddr(if_paddr), .if_fault(if_fault),
        .dm_req(dm_req), .dm_rs1(dm_rs1), .dm_imm(dm_imm), .dm_req_out(dm_req_out),
        .dm_paddr(dm_paddr), .dm_fault(dm_fault)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Configuration write; the model updates only on supervisor writes
    task automatic cfg_write(logic [1:0] sel, logic [31:0] d, logic sup);
        @(negedge clk);
        cfg_sel = sel; cfg_wdata = d; cfg_supervisor = sup; cfg_wr_en = 1'b1;
        #1 chk(sup ? "R7 priv_err low" : "R8 priv_err", {31'b0, cfg_priv_err}, {31'b0, ~sup});
        @(posedge clk);
        if (sup) m_reg[sel] = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(logic [1:0] sel, logic sup);
        @(negedge clk);
        cfg_sel = sel; cfg_supervisor = sup; cfg_rd_en = 1'b1;
        #1;
        chk("R9 rdata", cfg_rdata, sup ? m_reg[sel] : 32'h0);
        chk("R9 priv_err", {31'b0, cfg_priv_err}, {31'b0, ~sup});
        cfg_rd_en = 1'b0;
    endtask

    // Drive both channels and compare against the model
    task automatic access(logic fr, logic [31:0] fa, logic dr, logic [31:0] rs, logic [31:0] im);
        logic [31:0] dl;
        logic fok, dok;
        @(negedge clk);
        if_req = fr; if_addr = fa; dm_req = dr; dm_rs1 = rs; dm_imm = im;
        #1;
        dl  = rs + im;
        fok = fa < m_reg[1];
        dok = dl < m_reg[3];
        chk("R4/R5/R6 if_req_out", {31'b0, if_req_out}, {31'b0, fr & fok});
        chk("R4/R5/R6 if_fault", {31'b0, if_fault}, {31'b0, fr & ~fok});
        chk("R4/R5/R6 dm_req_out", {31'b0, dm_req_out}, {31'b0, dr & dok});
        chk("R4/R5/R6 dm_fault", {31'b0, dm_fault}, {31'b0, dr & ~dok});
        if (fr) chk("R2 if_paddr", if_paddr, fa + m_reg[0]);
        if (dr) chk("R3 dm_paddr", dm_paddr, m_reg[2] + rs + im);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        rst_n = 0; cfg_supervisor = 0; cfg_wr_en = 0; cfg_rd_en = 0; cfg_sel = 0; cfg_wdata = 0;
        if_req = 0; if_addr = 0; dm_req = 0; dm_rs1 = 0; dm_imm = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state
        for (int i = 0; i < 4; i++) cfg_read(2'(i), 1'b1);
        access(1, 32'h0, 1, 32'h0, 32'h0);
        chk("R1 fetch faults", {31'b0, if_fault}, 32'd1);
        chk("R1 data faults", {31'b0, dm_fault}, 32'd1);

        // R7/R9: program both windows
        cfg_write(2'd0, 32'h1000_0000, 1);
        cfg_write(2'd1, 32'h0000_0100, 1);
        cfg_write(2'd2, 32'hFFFF_FFF0, 1);
        cfg_write(2'd3, 32'h0001_0000, 1);
        for (int i = 0; i < 4; i++) cfg_read(2'(i), 1'b1);

        // R8/R9: user mode is refused
        cfg_write(2'd1, 32'hFFFF_FFFF, 0);
        cfg_read(2'd1, 1'b1);
        cfg_read(2'd0, 1'b0);

        // R4: edges of the limit
        access(1, 32'h0000_00FF, 1, 32'h0000_FFF0, 32'h0000_000F);
        access(1, 32'h0000_0100, 1, 32'h0000_FFF0, 32'h0000_0010);
        // R3: logical wrap and base carry
        access(0, 32'h0, 1, 32'hFFFF_FFF0, 32'h0000_0020);
        // R5: no request, illegal addresses
        access(0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 32'h0);
        // R6: fetch faults while data passes
        access(1, 32'h0000_0200, 1, 32'h0000_0200, 32'h0);

        // R10: write and access in the same cycle
        @(negedge clk);
        cfg_sel = 2'd0; cfg_wdata = 32'h2000_0000; cfg_supervisor = 1; cfg_wr_en = 1;
        if_req = 1; if_addr = 32'h10;
        #1 chk("R10 old base before edge", if_paddr, 32'h1000_0010);
        @(posedge clk); m_reg[0] = 32'h2000_0000;
        #1 chk("R10 new base after edge", if_paddr, 32'h2000_0010);
        @(negedge clk) cfg_wr_en = 0;

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int unsigned op = $urandom % 8;
            if (op == 0) cfg_write(2'($urandom % 4), ($urandom % 2) ? $urandom : ($urandom % 32'h400), 1'($urandom % 2));
            else if (op == 1) cfg_read(2'($urandom % 4), 1'($urandom % 2));
            else access(1'($urandom % 2), $urandom % (2 * m_reg[1] + 2),
                        1'($urandom % 2), $urandom % (2 * m_reg[3] + 2),
                        ($urandom % 2) ? 32'($urandom % 64) : -32'($urandom % 64));
        end

        finish_run();
    end
endmodule